// File: doc/BRIEF.md
# Lock-Guarded GPIO Pad-Mode Controller

This block is a memory-mapped GPIO controller for up to 32 pins. Software reaches it through a simple register bus with an address, a write strobe, write data and a combinational read-data path. Each pin has two mode bits, a high mode bit and a low mode bit, and one output data bit. Together these three bits select one of four pad drive styles. The block drives the pads through a per-pin output-enable signal and a per-pin output-value signal.

Output data is changed only through atomic set and clear registers. The two mode registers can be written directly, and each also has its own set and clear registers. Every mode write is guarded by a software lock. The lock arms only when a fixed key value is written. The lock register reports its own state in its top bit.

Pad inputs pass through a two-flop synchroniser before software can read them. At reset every pin is an input, all output data is zero and the lock is released.

Top module: `gpio_padmode_top`

## Requirements
- R1: After reset, every padOe bit is 0, and reads of the high-mode (0x08), low-mode (0x0C), data (0x14) and lock (0x80) registers return 0.
- R2: A pin whose mode pair {high,low} is 00 has padOe=0 and padOut=0 for either data value.
- R3: A pin in mode 01 has padOe=1, and padOut equals its data bit.
- R4: A pin in mode 10 drives low (padOe=1, padOut=0) when its data bit is 0, and floats (padOe=0) when its data bit is 1.
- R5: A pin in mode 11 floats (padOe=0) when its data bit is 0, and drives high (padOe=1, padOut=1) when its data bit is 1.
- R6: A write to data-set (0x14) sets, and a write to data-clear (0x18) clears, only the bit positions written as 1. Reading 0x14 or 0x18 returns the current output data.
- R7: While the lock is active, a write to 0x08 or 0x0C replaces the high or low mode register. The set registers, 0x4C for high and 0x54 for low, set the bits written as 1. The clear registers, 0x50 for high and 0x58 for low, clear the bits written as 1. The bits written as 0 are left unchanged.
- R8: While the lock is inactive, every write to 0x08, 0x0C, 0x4C, 0x50, 0x54 or 0x58 leaves both mode registers and the pads unchanged.
- R9: A write to the lock register (0x80) makes the lock active exactly when bits [15:0] equal 0xD42F, whatever the upper bits hold. Any other value releases it. A read of 0x80 returns bit 31 = lock active and all other bits 0.
- R10: A read of data-in (0x04) returns padIn as it was two rising edges earlier, through a two-flop synchroniser.
- R11: Register bits at or above the NPINS parameter read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| padIn | input | NPINS | Raw pad input levels |
| padOe | output | NPINS | Per-pin output enable |
| padOut | output | NPINS | Per-pin output value |

## Verification
The bench goes after the lock gate in several ways:
- A key with junk in its upper bits must still arm the lock.
- A key that is off by one, or a key in the wrong half of the word, must release the lock. A gate that looked at the whole word, or at the wrong bits, would arm or release wrongly.
- Mode writes attempted while the lock is released must change nothing. A leaky gate would alter the readback and the pads.

It also checks each of the four drive styles with both data values, where a swapped mode decode would float a pin that should drive, or drive one that should float. It checks that set and clear registers touch only the bits written as 1, against a reference model under random mixed writes. Finally, it reads data-in one edge after an input change to catch a synchroniser that is one stage short, and it writes to bits at or above the pin count to catch leakage there.

// File: rtl/gpio_padmode_pkg.sv
package gpio_padmode_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_DIN    = 8'h04;
  localparam logic [ADDR_W-1:0] A_HI     = 8'h08;
  localparam logic [ADDR_W-1:0] A_LO     = 8'h0C;
  localparam logic [ADDR_W-1:0] A_DSET   = 8'h14;
  localparam logic [ADDR_W-1:0] A_DCLR   = 8'h18;
  localparam logic [ADDR_W-1:0] A_HISET  = 8'h4C;
  localparam logic [ADDR_W-1:0] A_HICLR  = 8'h50;
  localparam logic [ADDR_W-1:0] A_LOSET  = 8'h54;
  localparam logic [ADDR_W-1:0] A_LOCLR  = 8'h58;
  localparam logic [ADDR_W-1:0] A_LOCK   = 8'h80;
  localparam logic [15:0] LOCK_KEY = 16'hD42F;

  typedef struct packed {
    logic dataSet;
    logic dataClr;
    logic hiWr;
    logic hiSet;
    logic hiClr;
    logic loWr;
    logic loSet;
    logic loClr;
  } wrStb_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIN, SEL_HI, SEL_LO, SEL_DATA, SEL_LOCK
  } rdSel_e;
endpackage

// File: rtl/gpio_padmode_ctrl.sv
module gpio_padmode_ctrl
  import gpio_padmode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       keyField,
  output wrStb_t            stb,
  output rdSel_e            rdSel,
  output logic              lockActive
);
  logic lockWr;
  logic modeOk;

  assign lockWr = busWrEn && (busAddr == A_LOCK);
  assign modeOk = busWrEn && lockActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockActive <= 1'b0;
    else if (lockWr) lockActive <= (keyField == LOCK_KEY);
  end

  always_comb begin
    stb = '0;
    stb.dataSet = busWrEn && (busAddr == A_DSET);
    stb.dataClr = busWrEn && (busAddr == A_DCLR);
    stb.hiWr    = modeOk && (busAddr == A_HI);
    stb.hiSet   = modeOk && (busAddr == A_HISET);
    stb.hiClr   = modeOk && (busAddr == A_HICLR);
    stb.loWr    = modeOk && (busAddr == A_LO);
    stb.loSet   = modeOk && (busAddr == A_LOSET);
    stb.loClr   = modeOk && (busAddr == A_LOCLR);
  end

  always_comb begin
    case (busAddr)
      A_DIN:          rdSel = SEL_DIN;
      A_HI:           rdSel = SEL_HI;
      A_LO:           rdSel = SEL_LO;
      A_DSET, A_DCLR: rdSel = SEL_DATA;
      A_LOCK:         rdSel = SEL_LOCK;
      default:        rdSel = SEL_NONE;
    endcase
  end

  AST_LOCK_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (lockWr && keyField == LOCK_KEY) |=> lockActive); // R9
  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (lockWr && keyField != LOCK_KEY) |=> !lockActive); // R9
  AST_MODE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hiWr || stb.hiSet || stb.hiClr || stb.loWr || stb.loSet || stb.loClr)
      |-> lockActive); // R8
endmodule

// File: rtl/gpio_padmode_dp.sv
module gpio_padmode_dp
  import gpio_padmode_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStb_t           stb,
  input  rdSel_e           rdSel,
  input  logic             lockActive,
  input  logic [NPINS-1:0] wrBits,
  input  logic [NPINS-1:0] padIn,
  output logic [NPINS-1:0] padOe,
  output logic [NPINS-1:0] padOut,
  output logic [31:0]      rdData
);
  logic [NPINS-1:0] modeHi, modeLo, dataQ;
  logic [NPINS-1:0] syncA, syncB;
  logic [31:0] rdExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeHi <= '0;
      modeLo <= '0;
      dataQ  <= '0;
      syncA  <= '0;
      syncB  <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      if (stb.hiWr)       modeHi <= wrBits;
      else if (stb.hiSet) modeHi <= modeHi | wrBits;
      else if (stb.hiClr) modeHi <= modeHi & ~wrBits;
      if (stb.loWr)       modeLo <= wrBits;
      else if (stb.loSet) modeLo <= modeLo | wrBits;
      else if (stb.loClr) modeLo <= modeLo & ~wrBits;
      if (stb.dataSet)      dataQ <= dataQ | wrBits;
      else if (stb.dataClr) dataQ <= dataQ & ~wrBits;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    always_comb begin
      unique case ({modeHi[p], modeLo[p]})
        2'b00: begin padOe[p] = 1'b0;      padOut[p] = 1'b0;     end
        2'b01: begin padOe[p] = 1'b1;      padOut[p] = dataQ[p]; end
        2'b10: begin padOe[p] = ~dataQ[p]; padOut[p] = 1'b0;     end
        default: begin padOe[p] = dataQ[p]; padOut[p] = 1'b1;    end
      endcase
    end
  end

  always_comb begin
    rdExt = '0;
    case (rdSel)
      SEL_DIN:  rdExt[NPINS-1:0] = syncB;
      SEL_HI:   rdExt[NPINS-1:0] = modeHi;
      SEL_LO:   rdExt[NPINS-1:0] = modeLo;
      SEL_DATA: rdExt[NPINS-1:0] = dataQ;
      SEL_LOCK: rdExt[31] = lockActive;
      default:  rdExt = '0;
    endcase
    rdData = rdExt;
  end

  AST_DATA_SET_ONLY_ONES: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataSet |=> (dataQ == ($past(dataQ) | $past(wrBits)))); // R6
  AST_DATA_CLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataClr |=> (dataQ == ($past(dataQ) & ~$past(wrBits)))); // R6
  AST_MODE_FROZEN_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !lockActive |=> ($stable(modeHi) && $stable(modeLo))); // R8
  AST_SYNC_TWO_STAGES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2)) |-> (syncB == $past(padIn, 2))); // R10
endmodule

// File: rtl/gpio_padmode_top.sv
module gpio_padmode_top
  import gpio_padmode_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busAddr,
  input  logic             busWrEn,
  input  logic [31:0]      busWrData,
  output logic [31:0]      busRdData,
  input  logic [NPINS-1:0] padIn,
  output logic [NPINS-1:0] padOe,
  output logic [NPINS-1:0] padOut
);
  wrStb_t stb;
  rdSel_e rdSel;
  logic   lockActive;

  gpio_padmode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .keyField(busWrData[15:0]), .stb(stb), .rdSel(rdSel), .lockActive(lockActive)
  );

  gpio_padmode_dp #(.NPINS(NPINS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .lockActive(lockActive),
    .wrBits(busWrData[NPINS-1:0]), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .rdData(busRdData)
  );

  initial begin
    assert (NPINS >= 1 && NPINS <= 32); // R11
  end
endmodule

// File: tb/gpio_padmode_top_test.sv
module gpio_padmode_top_test;
  localparam int NP = 20;
  localparam logic [31:0] PMASK = (32'h1 << NP) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOe, padOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] mHi = 0, mLo = 0, mData = 0;
  bit mLock = 0;

  always #2 clk = ~clk;

  gpio_padmode_top #(.NPINS(NP)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOe(padOe), .padOut(padOut)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expOe(logic [31:0] h, logic [31:0] l, logic [31:0] d);
    logic [31:0] r = 0;
    for (int i = 0; i < NP; i++)
      case ({h[i], l[i]})
        2'b00: r[i] = 0;
        2'b01: r[i] = 1;
        2'b10: r[i] = !d[i];
        default: r[i] = d[i];
      endcase
    return r;
  endfunction

  function automatic logic [31:0] expOut(logic [31:0] h, logic [31:0] l, logic [31:0] d);
    logic [31:0] r = 0;
    for (int i = 0; i < NP; i++)
      case ({h[i], l[i]})
        2'b00: r[i] = 0;
        2'b01: r[i] = d[i];
        2'b10: r[i] = 0;
        default: r[i] = 1;
      endcase
    return r;
  endfunction

  function automatic void model(logic [7:0] a, logic [31:0] v);
    logic [31:0] w = v & PMASK;
    case (a)
      8'h14: mData = mData | w;
      8'h18: mData = mData & ~w;
      8'h80: mLock = (v[15:0] == 16'hD42F);
      default: if (mLock) case (a)
        8'h08: mHi = w;
        8'h4C: mHi = mHi | w;
        8'h50: mHi = mHi & ~w;
        8'h0C: mLo = w;
        8'h54: mLo = mLo | w;
        8'h58: mLo = mLo & ~w;
        default: ;
      endcase
    endcase
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk);
    busAddr = a; busWrData = v; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    model(a, v);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #0.5;
    v = busRdData;
  endtask

  task automatic checkAll(string req);
    logic [31:0] v;
    rd(8'h08, v); check({req, " hi"}, v, mHi);
    rd(8'h0C, v); check({req, " lo"}, v, mLo);
    rd(8'h14, v); check({req, " data"}, v, mData);
    rd(8'h80, v); check({req, " lock"}, v, {mLock, 31'b0});
    check({req, " oe"}, 32'(padOe), expOe(mHi, mLo, mData));
    check({req, " out"}, 32'(padOut), expOut(mHi, mLo, mData));
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog expired");
    bad++;
    total++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] addrs [10] = '{8'h08, 8'h0C, 8'h14, 8'h18, 8'h4C,
                               8'h50, 8'h54, 8'h58, 8'h80, 8'h04};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");
    check("R1 oe", 32'(padOe), 0);

    // R8: mode writes while lock released are ignored
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h54, 32'h0000_00FF);
    checkAll("R8 unlocked");

    // R9: key with junk upper bits arms; near-miss releases
    wr(8'h80, 32'hABCD_D42F);
    rd(8'h80, v); check("R9 armed", v, 32'h8000_0000);
    wr(8'h80, 32'h0000_D42E);
    rd(8'h80, v); check("R9 nearmiss", v, 32'h0);
    wr(8'h80, 32'hD42F_0000);
    rd(8'h80, v); check("R9 upper half", v, 32'h0);
    wr(8'h0C, 32'h0000_000F);
    checkAll("R8 after release");

    // R2..R5: four modes with both data values, pins 0..7
    wr(8'h80, 32'h0000_D42F);
    wr(8'h08, 32'h0000_00F0); // hi on pins 4..7
    wr(8'h0C, 32'h0000_00CC); // lo on pins 2,3,6,7
    wr(8'h14, 32'h0000_00AA); // data 1 on odd pins
    checkAll("R2 R3 R4 R5 modes");
    check("R3 pin2 drive low", {31'b0, padOe[2]}, 1);
    check("R4 pin5 float", {31'b0, padOe[5]}, 0);
    check("R5 pin7 drive high", {30'b0, padOe[7], padOut[7]}, 2'b11);
    wr(8'h18, 32'h0000_00FF);
    checkAll("R2 R3 R4 R5 data0");

    // R7: set/clear registers for modes; R11: bits above NPINS ignored
    wr(8'h4C, 32'hFFF0_0003);
    wr(8'h50, 32'h0000_0001);
    wr(8'h58, 32'h0000_0044);
    checkAll("R7 R11 mode set clr");
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R11 data upper", v, PMASK);
    wr(8'h18, 32'h0001_0101);
    checkAll("R6 clr");

    // R10: synchroniser latency
    @(negedge clk);
    padIn = 20'hA5A5A;
    @(negedge clk);
    rd(8'h04, v); check("R10 one edge", v, 32'h0);
    @(negedge clk);
    rd(8'h04, v); check("R10 two edges", v, 32'h000A_5A5A);

    // random mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a = addrs[$urandom_range(0, 9)];
      logic [31:0] d = $urandom();
      if (a == 8'h80 && $urandom_range(0, 1)) d[15:0] = 16'hD42F;
      if (a == 8'h04) begin
        logic [NP-1:0] pv = NP'($urandom());
        padIn = pv;
        @(negedge clk); @(negedge clk);
        rd(8'h04, v); check("R10 random", v, 32'(pv));
      end else begin
        wr(a, d);
        checkAll("R6 R7 R8 R9 random");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule